// File: doc/BRIEF.md
# Word-to-Byte External Bus Sequencer

The block sits between a 16-bit processor-side request port and an 8-bit external data bus. A word request aimed at the external bus is carried out as two byte cycles. The even address goes first and carries the high byte of the word. The odd address follows and carries the low byte. Each byte cycle lasts until the external side raises READY.

A small internal address window is served in a different way. Requests that land in it go to a 16-bit internal port in a single bus cycle, and READY has no effect on them. A one-clock done pulse closes every request. The read-data register updates only the byte lanes that the request touched.

A request is a one-cycle `req_valid` pulse that is accepted only while the sequencer is idle. Word requests have address bit 0 cleared before the window decode and the byte split.

Top module: `word_byte_bus_seq`

## Requirements
- R1: An effective address in 0xF000..0xF0FB or 0xFFFC..0xFFFF selects the internal port (`int_en`). Any other address, such as 0xF0FC, 0xFFFB or 0xEFFF, selects the external bus (`ext_en`). The two enables are never high together.
- R2: An internal access takes exactly one bus cycle whatever the level of `ext_ready`. For a request pulsed at clock edge k, `rsp_done` is high in the cycle after edge k+2.
- R3: An internal byte access takes one cycle. An even address enables `int_be[1]`, which is data bits 15:8. An odd address enables `int_be[0]`, which is bits 7:0. A word access enables both. Byte write data is taken from the half of `req_wdata` that matches the address.
- R4: An external word access makes two byte transfers, first at the even address and then at the even address plus one. The even byte maps to bits 15:8 of the read and write data, and the odd byte maps to bits 7:0.
- R5: A byte cycle completes only on a clock edge where `ext_ready` is high. While `ext_ready` is low, the address, write data and strobe hold their values and no data is captured. With W low cycles per byte, done arrives 2+W cycles after the request for a byte access and 3+2W cycles after it for a word access.
- R6: On external writes, `ext_wr` is high and `ext_wdata` carries the addressed byte from the first cycle of each byte cycle.
- R7: An external or internal byte read replaces only the addressed half of `rsp_rdata`. Writes leave `rsp_rdata` unchanged.
- R8: `rsp_done` is a single-cycle pulse raised after the last byte cycle completes.
- R9: A request pulsed while the sequencer is busy is dropped. It causes no bus transfer and no done pulse.
- R10: A word request at an odd address is carried out at the address with bit 0 cleared.
- R11: After reset, `rsp_done`, `int_en` and `ext_en` are low and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request pulse |
| req_addr | input | 16 | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; bits 15:8 belong to the even byte |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Read data register |
| int_en | output | 1 | Internal port access cycle |
| int_we | output | 1 | Internal write |
| int_be | output | 2 | Internal byte enables (bit 1 = high byte) |
| int_addr | output | 16 | Internal address |
| int_wdata | output | 16 | Internal write data |
| int_rdata | input | 16 | Internal read data |
| ext_en | output | 1 | External byte cycle active |
| ext_wr | output | 1 | External write strobe |
| ext_addr | output | 16 | External byte address |
| ext_wdata | output | 8 | External write byte |
| ext_rdata | input | 8 | External read byte |
| ext_ready | input | 1 | External cycle may complete |

## Verification
The bench holds READY low during internal accesses. A design that waited on READY for those accesses would then miss its latency of two cycles. Word accesses go to external addresses just past both window edges and to an odd word address. A design that swapped the byte order, used the wrong window bounds or failed to align the address would log the wrong transfer addresses or return swapped halves. Byte reads follow a word read, so a design that disturbed the other half of the read register would return a wrong value. A second request is pulsed while an external word with waits is still running. A design that accepted it would write memory or give an extra done pulse.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    localparam int ADDR_W = 16;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INT,
        ST_EXT
    } seq_state_e;
endpackage

// File: rtl/wbs_win_decode.sv
module wbs_win_decode #(
    parameter int AW      = wbs_pkg::ADDR_W,
    parameter int NUM_WIN = 2,
    parameter logic [NUM_WIN*AW-1:0] WIN_LO = {16'hFFFC, 16'hF000},
    parameter logic [NUM_WIN*AW-1:0] WIN_HI = {16'hFFFF, 16'hF0FB}
) (
    input  logic [AW-1:0] addr,
    output logic          in_win
);
    logic [NUM_WIN-1:0] hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        assign hit[g] = (addr >= WIN_LO[g*AW +: AW]) && (addr <= WIN_HI[g*AW +: AW]);
    end

    assign in_win = |hit;
endmodule

// File: rtl/wbs_seq_core.sv
module wbs_seq_core
    import wbs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_word,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    input  logic          req_internal,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          int_en,
    output logic          int_we,
    output logic [DW/BW-1:0] int_be,
    output logic [AW-1:0] int_addr,
    output logic [DW-1:0] int_wdata,
    input  logic [DW-1:0] int_rdata,
    output logic          ext_en,
    output logic          ext_wr,
    output logic [AW-1:0] ext_addr,
    output logic [BW-1:0] ext_wdata,
    input  logic [BW-1:0] ext_rdata,
    input  logic          ext_ready
);
    localparam int NLANE  = DW / BW;
    localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1;
    localparam logic [LANE_W-1:0] LAST_BEAT = LANE_W'(NLANE - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [AW-1:0]     addr;
        logic [DW-1:0]     wdata;
        logic              word;
        logic              write;
        logic [LANE_W-1:0] beat;
        logic [DW-1:0]     rdata;
        logic              done;
    } seq_regs_t;

    seq_regs_t q, d;
    logic [AW-1:0]     bus_addr;
    logic [LANE_W-1:0] lane_idx;

    // even byte offset maps to the most significant lane
    assign bus_addr = {q.addr[AW-1:LANE_W], q.addr[LANE_W-1:0] | q.beat};
    assign lane_idx = LAST_BEAT - bus_addr[LANE_W-1:0];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.word  = req_word;
                    d.write = req_write;
                    d.wdata = req_wdata;
                    d.beat  = '0;
                    d.st    = req_internal ? ST_INT : ST_EXT;
                end
            end
            ST_INT: begin
                if (!q.write) begin
                    for (int l = 0; l < NLANE; l++) begin
                        if (q.word || (LANE_W'(l) == lane_idx)) begin
                            d.rdata[l*BW +: BW] = int_rdata[l*BW +: BW];
                        end
                    end
                end
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            ST_EXT: begin
                if (ext_ready) begin
                    if (!q.write) begin
                        for (int l = 0; l < NLANE; l++) begin
                            if (LANE_W'(l) == lane_idx) begin
                                d.rdata[l*BW +: BW] = ext_rdata;
                            end
                        end
                    end
                    if (!q.word || (q.beat == LAST_BEAT)) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ext_wdata = '0;
        for (int l = 0; l < NLANE; l++) begin
            if (LANE_W'(l) == lane_idx) begin
                ext_wdata = q.wdata[l*BW +: BW];
            end
        end
        for (int l = 0; l < NLANE; l++) begin
            int_be[l] = q.word || (LANE_W'(l) == lane_idx);
        end
    end

    assign int_en    = (q.st == ST_INT);
    assign int_we    = q.write;
    assign int_addr  = bus_addr;
    assign int_wdata = q.wdata;
    assign ext_en    = (q.st == ST_EXT);
    assign ext_wr    = ext_en && q.write;
    assign ext_addr  = bus_addr;
    assign rsp_done  = q.done;
    assign rsp_rdata = q.rdata;

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_int_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_en |=> (!int_en && rsp_done));

    assert_port_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_en && ext_en));

    assert_hold_on_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && !ext_ready) |=>
            (ext_en && $stable(ext_addr) && $stable(ext_wdata) && $stable(ext_wr)));

    assert_odd_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_en && ext_ready && q.word && (q.beat != LAST_BEAT)) |=>
            (ext_en && (ext_addr == AW'($past(ext_addr) + 1'b1))));
endmodule

// File: rtl/word_byte_bus_seq.sv
module word_byte_bus_seq
    import wbs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = WORD_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_word,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          int_en,
    output logic          int_we,
    output logic [DW/BW-1:0] int_be,
    output logic [AW-1:0] int_addr,
    output logic [DW-1:0] int_wdata,
    input  logic [DW-1:0] int_rdata,
    output logic          ext_en,
    output logic          ext_wr,
    output logic [AW-1:0] ext_addr,
    output logic [BW-1:0] ext_wdata,
    input  logic [BW-1:0] ext_rdata,
    input  logic          ext_ready
);
    localparam int NLANE  = DW / BW;
    localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1;

    logic [AW-1:0] eff_addr;
    logic          in_win;

    // word requests are aligned before decode and split
    assign eff_addr = req_word ? {req_addr[AW-1:LANE_W], {LANE_W{1'b0}}} : req_addr;

    wbs_win_decode #(.AW(AW)) u_decode (
        .addr   (eff_addr),
        .in_win (in_win)
    );

    wbs_seq_core #(.AW(AW), .DW(DW), .BW(BW)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_addr     (eff_addr),
        .req_word     (req_word),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .req_internal (in_win),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata),
        .int_en       (int_en),
        .int_we       (int_we),
        .int_be       (int_be),
        .int_addr     (int_addr),
        .int_wdata    (int_wdata),
        .int_rdata    (int_rdata),
        .ext_en       (ext_en),
        .ext_wr       (ext_wr),
        .ext_addr     (ext_addr),
        .ext_wdata    (ext_wdata),
        .ext_rdata    (ext_rdata),
        .ext_ready    (ext_ready)
    );
endmodule

// File: tb/word_byte_bus_seq_tb_top.sv
module word_byte_bus_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        int_en, int_we;
    logic [1:0]  int_be;
    logic [15:0] int_addr, int_wdata, int_rdata;
    logic        ext_en, ext_wr, ext_ready;
    logic [15:0] ext_addr;
    logic [7:0]  ext_wdata, ext_rdata;

    int checks = 0;
    int errors = 0;

    logic [15:0] int_mem [0:127];
    logic [7:0]  ext_mem [0:255];
    logic [15:0] xlog [0:255];
    int          log_n = 0;
    int          wcnt = 0;
    int          cur_waits = 0;
    logic        ready_en = 1'b0;
    logic [15:0] exp_rd = '0;

    always #4 clk = ~clk;

    word_byte_bus_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .int_en(int_en), .int_we(int_we),
        .int_be(int_be), .int_addr(int_addr), .int_wdata(int_wdata), .int_rdata(int_rdata),
        .ext_en(ext_en), .ext_wr(ext_wr), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata), .ext_ready(ext_ready)
    );

    function automatic int iidx(input logic [15:0] a);
        return (a[15:8] == 8'hF0) ? int'(a[7:1]) : 126 + int'(a[1]);
    endfunction

    function automatic bit in_win(input logic [15:0] a);
        return ((a >= 16'hF000) && (a <= 16'hF0FB)) || (a >= 16'hFFFC);
    endfunction

    assign int_rdata = int_mem[iidx(int_addr)];
    assign ext_rdata = ext_mem[ext_addr[7:0]];
    assign ext_ready = ready_en && (wcnt >= cur_waits);

    // bus-side device models
    always @(posedge clk) begin
        if (ext_en) begin
            if (ext_ready) begin
                wcnt <= 0;
                xlog[log_n[7:0]] <= ext_addr;
                log_n <= log_n + 1;
                if (ext_wr) ext_mem[ext_addr[7:0]] <= ext_wdata;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
        if (int_en && int_we) begin
            if (int_be[1]) int_mem[iidx(int_addr)][15:8] <= int_wdata[15:8];
            if (int_be[0]) int_mem[iidx(int_addr)][7:0]  <= int_wdata[7:0];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] a;
        logic        w;
        logic        wr;
        logic [15:0] d;
        logic [3:0]  ws;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'hF000, 1'b1, 1'b1, 16'h1234, 4'd0},
        '{16'hF000, 1'b1, 1'b0, 16'h0000, 4'd0},
        '{16'hF0FB, 1'b0, 1'b1, 16'h00AB, 4'd2},
        '{16'hF0FA, 1'b0, 1'b0, 16'h0000, 4'd0},
        '{16'hFFFE, 1'b1, 1'b1, 16'hBEEF, 4'd1},
        '{16'hFFFE, 1'b1, 1'b0, 16'h0000, 4'd0},
        '{16'hF0FC, 1'b1, 1'b1, 16'hCAFE, 4'd1},
        '{16'hF0FC, 1'b1, 1'b0, 16'h0000, 4'd2},
        '{16'hFFFB, 1'b0, 1'b0, 16'h0000, 4'd0},
        '{16'h2001, 1'b1, 1'b0, 16'h0000, 4'd1},
        '{16'h2030, 1'b0, 1'b1, 16'h5A00, 4'd3},
        '{16'h2031, 1'b0, 1'b1, 16'h00C3, 4'd0},
        '{16'h2030, 1'b1, 1'b0, 16'h0000, 4'd0},
        '{16'hEFFF, 1'b0, 1'b0, 16'h0000, 4'd2}
    };

    task automatic do_req(input vec_t v);
        logic [15:0] e;
        bit          intl;
        int          exp_lat, lat, start_n, nxfer;
        bit          wbad;
        logic [15:0] pre_int;
        e       = v.w ? {v.a[15:1], 1'b0} : v.a;
        intl    = in_win(e);
        exp_lat = intl ? 2 : (v.w ? 3 + 2 * int'(v.ws) : 2 + int'(v.ws));
        nxfer   = intl ? 0 : (v.w ? 2 : 1);
        pre_int = int_mem[iidx(e)];
        if (!v.wr) begin
            if (intl) begin
                if (v.w) exp_rd = pre_int;
                else if (e[0]) exp_rd[7:0] = pre_int[7:0];
                else exp_rd[15:8] = pre_int[15:8];
            end else begin
                if (v.w) exp_rd = {ext_mem[e[7:0]], ext_mem[e[7:0] | 8'h01]};
                else if (e[0]) exp_rd[7:0] = ext_mem[e[7:0]];
                else exp_rd[15:8] = ext_mem[e[7:0]];
            end
        end
        start_n   = log_n;
        cur_waits = int'(v.ws);
        ready_en  = !intl;
        req_addr  = v.a; req_word = v.w; req_write = v.wr; req_wdata = v.d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat  = 1;
        wbad = 0;
        while (!rsp_done && lat < 64) begin
            if (ext_en && ext_wr && (ext_wdata != (ext_addr[0] ? v.d[7:0] : v.d[15:8]))) wbad = 1;
            @(negedge clk);
            lat++;
        end
        // R2 R5 R8 latency
        chk(lat == exp_lat, intl ? "R2" : "R5", lat, exp_lat, "done latency");
        chk(rsp_rdata == exp_rd, "R7", rsp_rdata, exp_rd, "read data register");
        chk(log_n - start_n == nxfer, "R1", log_n - start_n, nxfer, "external transfer count");
        if (nxfer >= 1)
            chk(xlog[start_n[7:0]] == e, "R10", xlog[start_n[7:0]], e, "first byte address");
        if (nxfer == 2)
            chk(xlog[start_n[7:0] + 8'd1] == (e | 16'h1), "R4", xlog[start_n[7:0] + 8'd1],
                e | 16'h1, "second byte address");
        if (v.wr && !intl) chk(!wbad, "R6", 32'(wbad), 0, "write byte on bus");
        if (v.wr) begin
            if (intl) begin
                if (v.w)
                    chk(int_mem[iidx(e)] == v.d, "R3", int_mem[iidx(e)], v.d, "internal word write");
                else if (e[0])
                    chk(int_mem[iidx(e)] == {pre_int[15:8], v.d[7:0]}, "R3", int_mem[iidx(e)],
                        {pre_int[15:8], v.d[7:0]}, "internal odd byte write");
                else
                    chk(int_mem[iidx(e)] == {v.d[15:8], pre_int[7:0]}, "R3", int_mem[iidx(e)],
                        {v.d[15:8], pre_int[7:0]}, "internal even byte write");
            end else if (v.w) begin
                chk({ext_mem[e[7:0]], ext_mem[e[7:0] | 8'h01]} == v.d, "R4",
                    {ext_mem[e[7:0]], ext_mem[e[7:0] | 8'h01]}, v.d, "external word write order");
            end else begin
                chk(ext_mem[e[7:0]] == (e[0] ? v.d[7:0] : v.d[15:8]), "R6", ext_mem[e[7:0]],
                    e[0] ? v.d[7:0] : v.d[15:8], "external byte write");
            end
        end
        @(negedge clk);
        chk(!rsp_done, "R8", rsp_done, 0, "done single cycle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) int_mem[i] = 16'h4000 + 16'(i * 257);
        for (int i = 0; i < 256; i++) ext_mem[i] = 8'(i) ^ 8'h96;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!rsp_done && !int_en && !ext_en, "R11", {rsp_done, int_en, ext_en}, 0, "reset outputs");
        chk(rsp_rdata == 16'h0, "R11", rsp_rdata, 0, "reset read data");
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) do_req(VECS[i]);

        // R9: request while busy is dropped
        begin
            logic [15:0] pre40;
            int          sn, lat;
            bit          extra;
            pre40     = {ext_mem[8'h40], ext_mem[8'h41]};
            exp_rd    = {ext_mem[8'h10], ext_mem[8'h11]};
            sn        = log_n;
            cur_waits = 3;
            ready_en  = 1'b1;
            req_addr = 16'h2010; req_word = 1'b1; req_write = 1'b0; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            @(negedge clk);
            req_addr = 16'h2040; req_word = 1'b1; req_write = 1'b1; req_wdata = 16'hDEAD;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            lat = 3;
            while (!rsp_done && lat < 64) begin
                @(negedge clk);
                lat++;
            end
            chk(lat == 9, "R9", lat, 9, "busy-time latency");
            chk(rsp_rdata == exp_rd, "R9", rsp_rdata, exp_rd, "read data with dropped request");
            extra = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (rsp_done || ext_en || int_en) extra = 1;
            end
            chk(!extra, "R9", 32'(extra), 0, "activity after dropped request");
            chk({ext_mem[8'h40], ext_mem[8'h41]} == pre40, "R9",
                {ext_mem[8'h40], ext_mem[8'h41]}, pre40, "memory untouched");
            chk(log_n - sn == 2, "R9", log_n - sn, 2, "transfer count");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule